// File: doc/BRIEF.md
# Alternate Boot Supervisor

This block watches over firmware start-up on a system that holds two boot flash devices. A strap pin, sampled while the system is held in reset, arms a dedicated boot watchdog. From the end of reset the watchdog counts down once per tick-enable pulse, starting from a programmable reload value. Firmware that comes up correctly disarms the watchdog through a four-word register port. After that, the watchdog cannot fire again until the next reset.

If the count runs out first, the block raises a system reset request. It also exchanges the devices behind chip-select 0 and chip-select 1, so the next boot fetch is served by the other flash. The exchange flag and the reload value are held in flops that only power-on reset clears. The system reset that the block itself requests therefore leaves both intact. A later failure exchanges the roles again.

The register port has four word addresses, selected by `reg_addr`:

| Address | Register | Access | Contents |
|---|---|---|---|
| 0 | CTRL | read, write | bit 0 reads 1 while the watchdog runs; writing 0 to bit 0 disarms it |
| 1 | RELOAD | read, write | the reload value, all `CNT_W` bits |
| 2 | COUNT | read only | the current count |
| 3 | STATUS | read only | bit 0 is the swap flag; bit 1 is the strap level latched at the last reset |

Top module: `alt_boot_sup`

## Requirements
- R1: After power-on reset, `sys_rst_req` is 0, `cs0_dev` is 0 and `cs1_dev` is 1, and RELOAD reads `RELOAD_RST`.
- R2: The strap level present during the last reset cycle (either reset input low) is latched into STATUS bit 1. When that level is 1, CTRL bit 0 reads 1 and COUNT reads RELOAD once reset is released. When it is 0, the watchdog stays stopped, and ticks neither change COUNT nor raise a request.
- R3: While the watchdog runs, each cycle with `tick_en` high lowers COUNT by exactly one. Cycles without a tick, or any cycle while the watchdog is stopped, leave COUNT unchanged.
- R4: A write to CTRL with bit 0 = 0 stops the watchdog (CTRL bit 0 reads 0), and no request follows however many ticks arrive. A write to CTRL with bit 0 = 1 has no effect.
- R5: A tick that arrives while the watchdog runs and COUNT is 1 or 0 sets `sys_rst_req` at the next clock edge. The request then stays high until `sys_rst_n` is low for a cycle.
- R6: The same edge that sets the request inverts the swap flag. `cs0_dev` equals the flag, `cs1_dev` equals its inverse, and STATUS bit 0 reads the flag.
- R7: The swap flag and RELOAD keep their values through `sys_rst_n`. Only `por_n` clears them.
- R8: A write to RELOAD is ignored while the watchdog runs and is taken otherwise. The next reset loads COUNT from the new value.
- R9: A second expiry inverts the swap flag back, so that `cs0_dev` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low; clears all state |
| sys_rst_n | input | 1 | System reset, synchronous, active low; spares the swap flag and RELOAD |
| strap_en | input | 1 | Strap that enables the feature, sampled during reset |
| tick_en | input | 1 | Watchdog count-enable pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address: 0 CTRL, 1 RELOAD, 2 COUNT, 3 STATUS |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Register read data, combinational from `reg_addr` |
| sys_rst_req | output | 1 | System reset request, held until `sys_rst_n` |
| cs0_dev | output | 1 | Physical flash selected by chip-select 0 |
| cs1_dev | output | 1 | Physical flash selected by chip-select 1 |

## Verification
The assertions assume that both resets are synchronous and held low for at least one full clock edge. They also assume that the system above reacts to `sys_rst_req` by pulsing `sys_rst_n`, not by waiting on it. The bench drives every reset as a two-cycle low pulse. It asserts `sys_rst_n` only after it has observed the request, or at points where the test calls for a reset. All inputs change at the falling clock edge, so each write, tick or reset is seen by exactly one rising edge.

// File: rtl/abr_pkg.sv
package abr_pkg;
    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_COUNT  = 2'd2,
        REG_STATUS = 2'd3
    } abr_reg_e;
endpackage

// File: rtl/abr_wdog.sv
module abr_wdog #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             disarm,
    output logic             running,
    output logic             armed_at_reset,
    output logic [CNT_W-1:0] count,
    output logic             fire
);
    typedef struct packed {
        logic             en;
        logic             run;
        logic [CNT_W-1:0] cnt;
    } wd_t;

    wd_t wd_d, wd_q;

    always_comb begin
        wd_d = wd_q;
        fire = rst_n && wd_q.run && tick && (wd_q.cnt <= CNT_W'(1));
        if (!rst_n) begin
            wd_d.en  = strap;
            wd_d.run = strap;
            wd_d.cnt = load_val;
        end else if (fire) begin
            wd_d.run = 1'b0;
            wd_d.cnt = '0;
        end else if (disarm) begin
            wd_d.run = 1'b0;
        end else if (wd_q.run && tick) begin
            wd_d.cnt = wd_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        wd_q <= wd_d;
    end

    assign running        = wd_q.run;
    assign armed_at_reset = wd_q.en;
    assign count          = wd_q.cnt;

    // R3: without a tick, the count does not move
    a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick) |=> (wd_q.cnt == $past(wd_q.cnt)))
        else $error("a_r3_hold_without_tick");

    // R4: once stopped, the watchdog stays stopped until the next reset
    a_r4_stays_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!wd_q.run) |=> (!wd_q.run))
        else $error("a_r4_stays_stopped");
endmodule

// File: rtl/abr_persist.sv
module abr_persist #(
    parameter int             CNT_W      = 32,
    parameter logic [CNT_W-1:0] RELOAD_RST = CNT_W'(1000)
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             fire,
    input  logic             wd_running,
    input  logic             reload_we,
    input  logic [CNT_W-1:0] reload_wdata,
    output logic             swap,
    output logic [CNT_W-1:0] reload
);
    typedef struct packed {
        logic             swap;
        logic [CNT_W-1:0] reload;
    } keep_t;

    keep_t kp_d, kp_q;

    always_comb begin
        kp_d = kp_q;
        if (!por_n) begin
            kp_d.swap   = 1'b0;
            kp_d.reload = RELOAD_RST;
        end else begin
            if (fire) begin
                kp_d.swap = ~kp_q.swap;
            end
            if (reload_we && !wd_running) begin
                kp_d.reload = reload_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        kp_q <= kp_d;
    end

    assign swap   = kp_q.swap;
    assign reload = kp_q.reload;

    // R7: the swap flag moves only on an expiry
    a_r7_swap_holds: assert property (@(posedge clk) disable iff (!por_n)
        (!fire) |=> $stable(kp_q.swap))
        else $error("a_r7_swap_holds");

    // R8: a reload write while running leaves the value unchanged
    a_r8_reload_frozen: assert property (@(posedge clk) disable iff (!por_n)
        (reload_we && wd_running) |=> $stable(kp_q.reload))
        else $error("a_r8_reload_frozen");
endmodule

// File: rtl/alt_boot_sup.sv
module alt_boot_sup #(
    parameter int             CNT_W      = 32,
    parameter logic [CNT_W-1:0] RELOAD_RST = CNT_W'(1000)
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_rst_n,
    input  logic             strap_en,
    input  logic             tick_en,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             sys_rst_req,
    output logic             cs0_dev,
    output logic             cs1_dev
);
    import abr_pkg::*;

    typedef struct packed {
        logic req;
    } top_t;

    logic             rst_any_n;
    logic             wd_run, wd_en, wd_fire, swap;
    logic [CNT_W-1:0] wd_cnt, reload;
    logic             disarm, reload_we;
    abr_reg_e         sel;
    top_t             top_d, top_q;

    assign rst_any_n = por_n && sys_rst_n;
    assign sel       = abr_reg_e'(reg_addr);
    assign disarm    = reg_we && (sel == REG_CTRL) && !reg_wdata[0];
    assign reload_we = reg_we && (sel == REG_RELOAD);

    abr_wdog #(.CNT_W(CNT_W)) u_wdog (
        .clk            (clk),
        .rst_n          (rst_any_n),
        .strap          (strap_en),
        .load_val       (reload),
        .tick           (tick_en),
        .disarm         (disarm),
        .running        (wd_run),
        .armed_at_reset (wd_en),
        .count          (wd_cnt),
        .fire           (wd_fire)
    );

    abr_persist #(.CNT_W(CNT_W), .RELOAD_RST(RELOAD_RST)) u_persist (
        .clk          (clk),
        .por_n        (por_n),
        .fire         (wd_fire),
        .wd_running   (wd_run),
        .reload_we    (reload_we),
        .reload_wdata (reg_wdata),
        .swap         (swap),
        .reload       (reload)
    );

    always_comb begin
        top_d = top_q;
        if (!rst_any_n) begin
            top_d.req = 1'b0;
        end else if (wd_fire) begin
            top_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        top_q <= top_d;
    end

    always_comb begin
        case (sel)
            REG_CTRL:   reg_rdata = CNT_W'(wd_run);
            REG_RELOAD: reg_rdata = reload;
            REG_COUNT:  reg_rdata = wd_cnt;
            default:    reg_rdata = CNT_W'({wd_en, swap});
        endcase
    end

    assign sys_rst_req = top_q.req;
    assign cs0_dev     = swap;
    assign cs1_dev     = ~swap;

    // R5: the request stays high until a reset
    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_any_n)
        sys_rst_req |=> sys_rst_req)
        else $error("a_r5_req_held");

    // R4: a stopped watchdog raises no new request
    a_r4_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_any_n)
        (!wd_run && !sys_rst_req) |=> !sys_rst_req)
        else $error("a_r4_quiet_when_stopped");

    // R6: a new request comes with an exchanged chip-select mapping
    a_r6_swap_with_req: assert property (@(posedge clk) disable iff (!rst_any_n)
        $rose(sys_rst_req) |-> (cs0_dev != $past(cs0_dev)))
        else $error("a_r6_swap_with_req");

    // R3: a running count only moves downward
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_any_n)
        wd_run |=> (wd_cnt <= $past(wd_cnt)))
        else $error("a_r3_count_down");
endmodule

// File: tb/tb_alt_boot_sup.sv
module tb_alt_boot_sup;
    localparam int CNT_W = 32;
    localparam logic [CNT_W-1:0] RLD = 32'd8;

    localparam logic [2:0] OP_POR = 3'd0, OP_SYS = 3'd1, OP_WR = 3'd2,
                           OP_RD = 3'd3, OP_TICK = 3'd4, OP_OUT = 3'd5;

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 41;
    // OP_OUT expects {sys_rst_req, cs1_dev, cs0_dev}
    localparam vec_t VEC [NV] = '{
        '{OP_POR,  2'd0, 32'd1,  4'd1},  // R1
        '{OP_OUT,  2'd0, 32'd2,  4'd1},  // R1
        '{OP_RD,   2'd3, 32'd2,  4'd2},  // R2 status strap=1
        '{OP_RD,   2'd0, 32'd1,  4'd2},  // R2 running
        '{OP_RD,   2'd2, 32'd8,  4'd2},  // R2 count = reload
        '{OP_TICK, 2'd0, 32'd3,  4'd3},  // R3
        '{OP_RD,   2'd2, 32'd5,  4'd3},  // R3
        '{OP_WR,   2'd1, 32'd20, 4'd8},  // R8 ignored while running
        '{OP_RD,   2'd1, 32'd8,  4'd8},  // R8
        '{OP_TICK, 2'd0, 32'd4,  4'd5},  // R5 count reaches 1
        '{OP_OUT,  2'd0, 32'd2,  4'd5},  // R5 no request yet
        '{OP_TICK, 2'd0, 32'd1,  4'd5},  // R5 expiry
        '{OP_OUT,  2'd0, 32'd5,  4'd6},  // R6 request + swap
        '{OP_RD,   2'd3, 32'd3,  4'd6},  // R6 status
        '{OP_TICK, 2'd0, 32'd2,  4'd5},  // R5 held
        '{OP_OUT,  2'd0, 32'd5,  4'd5},  // R5
        '{OP_SYS,  2'd0, 32'd1,  4'd7},  // R7
        '{OP_OUT,  2'd0, 32'd1,  4'd7},  // R7 swap survives
        '{OP_RD,   2'd3, 32'd3,  4'd7},  // R7
        '{OP_RD,   2'd2, 32'd8,  4'd7},  // R7 reload kept
        '{OP_WR,   2'd0, 32'd1,  4'd4},  // R4 write 1: no effect
        '{OP_RD,   2'd0, 32'd1,  4'd4},  // R4
        '{OP_WR,   2'd0, 32'd0,  4'd4},  // R4 disarm
        '{OP_RD,   2'd0, 32'd0,  4'd4},  // R4
        '{OP_TICK, 2'd0, 32'd10, 4'd4},  // R4
        '{OP_OUT,  2'd0, 32'd1,  4'd4},  // R4 no request
        '{OP_RD,   2'd2, 32'd8,  4'd3},  // R3 stopped count frozen
        '{OP_WR,   2'd1, 32'd3,  4'd8},  // R8 accepted when stopped
        '{OP_RD,   2'd1, 32'd3,  4'd8},  // R8
        '{OP_SYS,  2'd0, 32'd1,  4'd8},  // R8
        '{OP_RD,   2'd2, 32'd3,  4'd8},  // R8 new load
        '{OP_TICK, 2'd0, 32'd3,  4'd9},  // R9 second expiry
        '{OP_OUT,  2'd0, 32'd6,  4'd9},  // R9 swapped back
        '{OP_RD,   2'd3, 32'd2,  4'd9},  // R9
        '{OP_SYS,  2'd0, 32'd0,  4'd2},  // R2 strap low
        '{OP_RD,   2'd0, 32'd0,  4'd2},  // R2
        '{OP_TICK, 2'd0, 32'd5,  4'd2},  // R2
        '{OP_OUT,  2'd0, 32'd2,  4'd2},  // R2
        '{OP_RD,   2'd3, 32'd0,  4'd2},  // R2
        '{OP_POR,  2'd0, 32'd1,  4'd1},  // R1
        '{OP_RD,   2'd1, 32'd8,  4'd1}   // R1 reload back to default
    };

    logic             clk = 1'b0;
    logic             por_n = 1'b0, sys_rst_n = 1'b1, strap_en = 1'b0, tick_en = 1'b0;
    logic             reg_we = 1'b0;
    logic [1:0]       reg_addr = 2'd0;
    logic [CNT_W-1:0] reg_wdata = '0;
    logic [CNT_W-1:0] reg_rdata;
    logic             sys_rst_req, cs0_dev, cs1_dev;
    int               n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    alt_boot_sup #(.CNT_W(CNT_W), .RELOAD_RST(RLD)) dut (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .strap_en(strap_en),
        .tick_en(tick_en), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sys_rst_req(sys_rst_req), .cs0_dev(cs0_dev), .cs1_dev(cs1_dev)
    );

    task automatic check(input int rq, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL R%0d: got %0d expected %0d", rq, got, exp);
        end
    endtask

    task automatic do_por(input logic s);
        strap_en = s; por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
    endtask

    task automatic do_sys(input logic s);
        strap_en = s; sys_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        sys_rst_n = 1'b1;
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] a, input logic [31:0] e, input int rq);
        reg_addr = a;
        #1;
        check(rq, reg_rdata, e);
    endtask

    task automatic do_tick(input int n);
        for (int k = 0; k < n; k++) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    task automatic do_out(input logic [2:0] e, input int rq);
        check(rq, {29'd0, sys_rst_req, cs1_dev, cs0_dev}, {29'd0, e});
    endtask

    initial begin
        @(negedge clk);
        for (int i = 0; i < NV; i++) begin
            case (VEC[i].op)
                OP_POR:  do_por(VEC[i].data[0]);
                OP_SYS:  do_sys(VEC[i].data[0]);
                OP_WR:   do_wr(VEC[i].addr, VEC[i].data);
                OP_RD:   do_rd(VEC[i].addr, VEC[i].data, int'(VEC[i].req));
                OP_TICK: do_tick(int'(VEC[i].data));
                default: do_out(VEC[i].data[2:0], int'(VEC[i].req));
            endcase
        end

        // R5 corner: reload 0 expires on the first tick
        do_por(1'b0);
        do_wr(2'd1, 32'd0);
        do_sys(1'b1);
        do_rd(2'd2, 32'd0, 5);
        do_tick(1);
        do_out(3'b101, 5);
        do_rd(2'd3, 32'd3, 6);

        // R7: power-on reset clears the swap flag
        do_por(1'b1);
        do_out(3'b010, 7);
        do_rd(2'd3, 32'd2, 7);

        // R2: a system reset mid-count reloads the counter
        do_tick(2);
        do_rd(2'd2, 32'd6, 3);
        do_sys(1'b1);
        do_rd(2'd2, 32'd8, 2);
        do_out(3'b010, 2);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule